// File: doc/BRIEF.md
# Sparse Fiber Format Encoder

The encoder accepts a dense one-dimensional fiber of fixed length, one element per accepted beat, and turns it into four compressed descriptions of the same data at once. Two of them depend only on the fiber length: a presence bitmask and an array of running nonzero counts (one entry per position plus a final total). The other two depend on how many nonzeros there are: a coordinate/value list and a zero-run/value list. The list outputs are streams, produced one cycle after the element that causes them. The bitmask and count array appear as whole vectors together with a one-cycle completion pulse.

Each accepted element is classified as zero or nonzero. A position counter supplies coordinates, a run counter tracks zeros since the last emitted run entry, and a prefix counter accumulates the count array. The run counter has a fixed width. When a zero run would grow past its largest value, an explicit zero-valued entry carrying the saturated count is emitted, and counting restarts.

Top module: `fiber_sparse_encoder`

## Requirements
- R1: On the completion cycle, `bm_bits` holds one bit per fiber position. Position p maps to bit index N-1-p, so position 0 is the leftmost bit. A bit is 1 exactly when that element was nonzero. For the fiber 0,0,c,d,0,f the value is 6'b001101.
- R2: For each nonzero element, `cp_valid` is high for one cycle, one clock after the element is accepted. `cp_coord` gives its position (0 = first element of the fiber) and `cp_data` its value. Entries come out in position order, so 0,0,c,d,0,f yields (2,c),(3,d),(5,f).
- R3: In the same cycle as each coordinate entry, `rl_valid` is high. `rl_run` gives the number of zeros since the previous run entry, or since the fiber start, and `rl_data` gives the value. The example fiber yields (2,c),(0,d),(1,f).
- R4: Suppose a zero is accepted while the pending run count already equals 2**RUN_W-1. The block then emits a run entry with `rl_run` = 2**RUN_W-1 and `rl_data` = 0, and no coordinate entry. The count restarts at 0. This is the only case in which a zero value appears on `rl_data`.
- R5: On the completion cycle, `offs_flat` holds N+1 fields of OFS_W bits. Field i sits at bits [i*OFS_W +: OFS_W] and equals the number of nonzeros at positions below i. Field N is the total. The example fiber gives 0,0,0,1,2,2,3.
- R6: Zeros after the last nonzero produce no coordinate entry. They produce no run entry unless R4 applies. An all-zero fiber gives no coordinate entry, an all-zero bitmask, all-zero count fields and a normal completion pulse.
- R7: `done` is high for exactly one cycle, one clock after the element marked by `in_last` is accepted. An element marked by `in_first` restarts the position, run and nonzero counts.
- R8: `in_ready` is always high outside reset. Cycles with `in_valid` low emit nothing and do not advance the position, so idle gaps inside a fiber leave every output unchanged.
- R9: After reset, `done`, `cp_valid` and `rl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Element beat valid |
| in_ready | output | 1 | Element beat accepted |
| in_data | input | DATA_W | Element value |
| in_first | input | 1 | Marks position 0 of a fiber |
| in_last | input | 1 | Marks the final position of a fiber |
| cp_valid | output | 1 | Coordinate entry valid |
| cp_coord | output | CRD_W | Position of the nonzero |
| cp_data | output | DATA_W | Value of the nonzero |
| rl_valid | output | 1 | Run entry valid |
| rl_run | output | RUN_W | Zeros preceding this entry |
| rl_data | output | DATA_W | Value (0 for a saturation entry) |
| done | output | 1 | Fiber complete, vectors valid |
| bm_bits | output | N | Presence bitmask |
| offs_flat | output | (N+1)*OFS_W | Running nonzero counts |

## Verification
The bench builds the block with its defaults: fiber length 6, 8-bit values and a 2-bit run counter. With these values every one of the 64 zero/nonzero patterns of a fiber can be driven, both back to back and with idle gaps inside the fiber. The 2-bit run counter saturates at 3, so the saturation entry is reached in several patterns. These include the all-zero fiber, which saturates once and leaves two trailing zeros, and patterns where saturation falls in the middle and is followed by a nonzero.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // largest value held by a run counter of the given width
  function automatic int unsigned run_limit(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction
endpackage

// File: rtl/sfe_elem_track.sv
module sfe_elem_track #(
  parameter int N      = 6,
  parameter int DATA_W = 8,
  localparam int CRD_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              acc,
  output logic              acc_first,
  output logic              acc_last,
  output logic              acc_nz,
  output logic [CRD_W-1:0]  acc_pos,
  output logic [DATA_W-1:0] acc_data
);
  logic [CRD_W-1:0] pos_q, pos_d;

  always_comb begin
    acc       = in_valid;
    acc_first = in_first;
    acc_last  = in_last;
    acc_data  = in_data;
    acc_nz    = (in_data != '0);
    acc_pos   = in_first ? '0 : pos_q;
    pos_d     = pos_q;
    if (acc) pos_d = acc_pos + CRD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  pos_q <= '0;
    else if (acc) pos_q <= pos_d;
  end
endmodule

// File: rtl/sfe_coord_emit.sv
module sfe_coord_emit #(
  parameter int N      = 6,
  parameter int DATA_W = 8,
  localparam int CRD_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              acc,
  input  logic              acc_nz,
  input  logic [CRD_W-1:0]  acc_pos,
  input  logic [DATA_W-1:0] acc_data,
  output logic              cp_valid,
  output logic [CRD_W-1:0]  cp_coord,
  output logic [DATA_W-1:0] cp_data
);
  logic              vld_d;
  logic              load_en;

  always_comb begin
    vld_d   = acc & acc_nz;
    load_en = vld_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cp_valid <= 1'b0;
    else         cp_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cp_coord <= '0;
      cp_data  <= '0;
    end else if (load_en) begin
      cp_coord <= acc_pos;
      cp_data  <= acc_data;
    end
  end
endmodule

// File: rtl/sfe_run_emit.sv
module sfe_run_emit #(
  parameter int DATA_W = 8,
  parameter int RUN_W  = 2,
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(sfe_pkg::run_limit(RUN_W))
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              acc,
  input  logic              acc_first,
  input  logic              acc_nz,
  input  logic [DATA_W-1:0] acc_data,
  output logic              rl_valid,
  output logic [RUN_W-1:0]  rl_run,
  output logic [DATA_W-1:0] rl_data
);
  logic [RUN_W-1:0]  run_q, run_d, run_base;
  logic              emit;
  logic [RUN_W-1:0]  run_out;
  logic [DATA_W-1:0] data_out;

  always_comb begin
    run_base = acc_first ? '0 : run_q;
    run_d    = run_q;
    emit     = 1'b0;
    run_out  = run_base;
    data_out = acc_data;
    if (acc) begin
      if (acc_nz) begin
        emit  = 1'b1;
        run_d = '0;
      end else if (run_base == RUN_MAX) begin
        emit     = 1'b1;
        run_out  = RUN_MAX;
        data_out = '0;
        run_d    = '0;
      end else begin
        run_d = run_base + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  run_q <= '0;
    else if (acc) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rl_valid <= 1'b0;
    else         rl_valid <= emit;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rl_run  <= '0;
      rl_data <= '0;
    end else if (emit) begin
      rl_run  <= run_out;
      rl_data <= data_out;
    end
  end
endmodule

// File: rtl/sfe_dense_meta.sv
module sfe_dense_meta #(
  parameter int N      = 6,
  localparam int CRD_W = $clog2(N),
  localparam int OFS_W = $clog2(N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   acc,
  input  logic                   acc_first,
  input  logic                   acc_last,
  input  logic                   acc_nz,
  input  logic [CRD_W-1:0]       acc_pos,
  output logic                   done,
  output logic [N-1:0]           bm_bits,
  output logic [(N+1)*OFS_W-1:0] offs_flat
);
  logic [OFS_W-1:0] cnt_q, cnt_d, cnt_base;
  logic [OFS_W-1:0] pos_w;
  logic [N-1:0]     bm_d;

  always_comb begin
    pos_w    = OFS_W'(acc_pos);
    cnt_base = acc_first ? '0 : cnt_q;
    cnt_d    = cnt_base + OFS_W'(acc_nz);
    bm_d     = acc_first ? '0 : bm_bits;
    for (int p = 0; p < N; p++) begin
      if (acc_nz && (pos_w == OFS_W'(p))) bm_d[N-1-p] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      bm_bits <= '0;
    end else if (acc) begin
      cnt_q   <= cnt_d;
      bm_bits <= bm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) done <= 1'b0;
    else         done <= acc & acc_last;
  end

  // one count register per field of the array
  for (genvar i = 0; i <= N; i++) begin : g_ofs
    logic [OFS_W-1:0] fld_q, fld_d;
    always_comb begin
      fld_d = acc_first ? '0 : fld_q;
      if (pos_w == OFS_W'(i))                      fld_d = cnt_base;
      if (acc_last && (pos_w + OFS_W'(1) == OFS_W'(i))) fld_d = cnt_d;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  fld_q <= '0;
      else if (acc) fld_q <= fld_d;
    end
    assign offs_flat[i*OFS_W +: OFS_W] = fld_q;
  end
endmodule

// File: rtl/fiber_sparse_encoder.sv
module fiber_sparse_encoder #(
  parameter int N      = 6,
  parameter int DATA_W = 8,
  parameter int RUN_W  = 2,
  localparam int CRD_W = $clog2(N),
  localparam int OFS_W = $clog2(N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   in_first,
  input  logic                   in_last,
  output logic                   cp_valid,
  output logic [CRD_W-1:0]       cp_coord,
  output logic [DATA_W-1:0]      cp_data,
  output logic                   rl_valid,
  output logic [RUN_W-1:0]       rl_run,
  output logic [DATA_W-1:0]      rl_data,
  output logic                   done,
  output logic [N-1:0]           bm_bits,
  output logic [(N+1)*OFS_W-1:0] offs_flat
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              acc, acc_first, acc_last, acc_nz;
  logic [CRD_W-1:0]  acc_pos;
  logic [DATA_W-1:0] acc_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s    = rst_pipe[1];
  assign in_ready = rst_s;

  sfe_elem_track #(.N(N), .DATA_W(DATA_W)) u_track (
    .clk(clk), .rst_ni(rst_s),
    .in_valid(in_valid & rst_s), .in_data(in_data),
    .in_first(in_first), .in_last(in_last),
    .acc(acc), .acc_first(acc_first), .acc_last(acc_last),
    .acc_nz(acc_nz), .acc_pos(acc_pos), .acc_data(acc_data)
  );

  sfe_coord_emit #(.N(N), .DATA_W(DATA_W)) u_coord (
    .clk(clk), .rst_ni(rst_s),
    .acc(acc), .acc_nz(acc_nz), .acc_pos(acc_pos), .acc_data(acc_data),
    .cp_valid(cp_valid), .cp_coord(cp_coord), .cp_data(cp_data)
  );

  sfe_run_emit #(.DATA_W(DATA_W), .RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_ni(rst_s),
    .acc(acc), .acc_first(acc_first), .acc_nz(acc_nz), .acc_data(acc_data),
    .rl_valid(rl_valid), .rl_run(rl_run), .rl_data(rl_data)
  );

  sfe_dense_meta #(.N(N)) u_dense (
    .clk(clk), .rst_ni(rst_s),
    .acc(acc), .acc_first(acc_first), .acc_last(acc_last),
    .acc_nz(acc_nz), .acc_pos(acc_pos),
    .done(done), .bm_bits(bm_bits), .offs_flat(offs_flat)
  );
endmodule

// File: rtl/fiber_sparse_encoder_chk.sv
module fiber_sparse_encoder_chk #(
  parameter int N      = 6,
  parameter int DATA_W = 8,
  parameter int RUN_W  = 2,
  localparam int CRD_W = $clog2(N),
  localparam int OFS_W = $clog2(N + 1)
) (
  input logic                   clk,
  input logic                   rst_s,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_last,
  input logic                   cp_valid,
  input logic [CRD_W-1:0]       cp_coord,
  input logic [DATA_W-1:0]      cp_data,
  input logic                   rl_valid,
  input logic [RUN_W-1:0]       rl_run,
  input logic [DATA_W-1:0]      rl_data,
  input logic                   done,
  input logic [N-1:0]           bm_bits,
  input logic [(N+1)*OFS_W-1:0] offs_flat
);
  localparam logic [RUN_W-1:0] RMAX = RUN_W'(sfe_pkg::run_limit(RUN_W));

  p_cp_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_s)
    cp_valid |-> (cp_data != '0) && (int'(cp_coord) < N));

  p_cp_pairs_rl_r3: assert property (@(posedge clk) disable iff (!rst_s)
    cp_valid |-> rl_valid && (rl_data == cp_data));

  p_zero_only_sat_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (rl_valid && rl_data == '0) |-> (rl_run == RMAX) && !cp_valid);

  p_total_matches_mask_r5: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (int'(offs_flat[N*OFS_W +: OFS_W]) == $countones(bm_bits)));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready && in_last) |=> done);

  p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done || $past(in_valid && in_ready && in_last));

  p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !(in_valid && in_ready) |=> !cp_valid && !rl_valid && !done);
endmodule

bind fiber_sparse_encoder fiber_sparse_encoder_chk #(
  .N(N), .DATA_W(DATA_W), .RUN_W(RUN_W)
) u_chk (
  .clk(clk), .rst_s(rst_s), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .cp_valid(cp_valid), .cp_coord(cp_coord),
  .cp_data(cp_data), .rl_valid(rl_valid), .rl_run(rl_run),
  .rl_data(rl_data), .done(done), .bm_bits(bm_bits), .offs_flat(offs_flat)
);

// File: tb/fiber_sparse_encoder_tb_top.sv
`timescale 1ns/1ps
module fiber_sparse_encoder_tb_top;
  localparam int N = 6, DATA_W = 8, RUN_W = 2;
  localparam int CRD_W = $clog2(N), OFS_W = $clog2(N + 1);
  localparam int RMAX = (1 << RUN_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_first, in_last;
  logic [DATA_W-1:0] in_data;
  logic cp_valid, rl_valid, done;
  logic [CRD_W-1:0] cp_coord;
  logic [DATA_W-1:0] cp_data, rl_data;
  logic [RUN_W-1:0] rl_run;
  logic [N-1:0] bm_bits;
  logic [(N+1)*OFS_W-1:0] offs_flat;

  always #10 clk = ~clk;  // 50 MHz

  fiber_sparse_encoder #(.N(N), .DATA_W(DATA_W), .RUN_W(RUN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .cp_valid(cp_valid), .cp_coord(cp_coord), .cp_data(cp_data),
    .rl_valid(rl_valid), .rl_run(rl_run), .rl_data(rl_data),
    .done(done), .bm_bits(bm_bits), .offs_flat(offs_flat)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  int cp_n, rl_n, done_n;
  int cp_c [16]; int cp_d [16];
  int rl_r [16]; int rl_d [16];
  logic [N-1:0] got_bm;
  logic [(N+1)*OFS_W-1:0] got_offs;

  always @(negedge clk) begin
    if (cp_valid && cp_n < 16) begin cp_c[cp_n] = int'(cp_coord); cp_d[cp_n] = int'(cp_data); end
    if (cp_valid) cp_n++;
    if (rl_valid && rl_n < 16) begin rl_r[rl_n] = int'(rl_run); rl_d[rl_n] = int'(rl_data); end
    if (rl_valid) rl_n++;
    if (done) begin done_n++; got_bm = bm_bits; got_offs = offs_flat; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int val_of(input int pat, input int p);
    return ((pat * 7 + p * 13) % 255) + 1;
  endfunction

  task automatic run_fiber(input int pat, input bit gaps);
    int ecp_c [16]; int ecp_d [16]; int ecp_n;
    int erl_r [16]; int erl_d [16]; int erl_n;
    int run, cnt, ebm;
    int eofs [N+1];
    cp_n = 0; rl_n = 0; done_n = 0;
    ecp_n = 0; erl_n = 0; run = 0; cnt = 0; ebm = 0;
    for (int p = 0; p < N; p++) begin
      bit nz = ((pat >> p) & 1) != 0;
      eofs[p] = cnt;
      if (nz) begin
        ebm |= 1 << (N - 1 - p);
        ecp_c[ecp_n] = p; ecp_d[ecp_n] = val_of(pat, p); ecp_n++;
        erl_r[erl_n] = run; erl_d[erl_n] = val_of(pat, p); erl_n++;
        run = 0; cnt++;
      end else if (run == RMAX) begin
        erl_r[erl_n] = RMAX; erl_d[erl_n] = 0; erl_n++;
        run = 0;
      end else run++;
    end
    eofs[N] = cnt;
    for (int p = 0; p < N; p++) begin
      if (gaps && (p == 1 || p == 4)) begin
        in_valid = 1'b0; in_data = 8'hA5; in_first = 1'b1; in_last = 1'b1;
        @(negedge clk);
        in_first = 1'b0; in_last = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = (((pat >> p) & 1) != 0) ? DATA_W'(val_of(pat, p)) : '0;
      in_first = (p == 0);
      in_last  = (p == N - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_data = '0;
    #1;
    chk(done_n == 1, "R7 done pulses", done_n, 1);
    chk(int'(got_bm) == ebm, "R1 bitmask", int'(got_bm), ebm);
    for (int i = 0; i <= N; i++)
      chk(int'(got_offs[i*OFS_W +: OFS_W]) == eofs[i], "R5 offset field",
          int'(got_offs[i*OFS_W +: OFS_W]), eofs[i]);
    chk(cp_n == ecp_n, (ecp_n == 0) ? "R6 coord count" : "R2 coord count", cp_n, ecp_n);
    for (int i = 0; i < ecp_n && i < cp_n; i++) begin
      chk(cp_c[i] == ecp_c[i], "R2 coord", cp_c[i], ecp_c[i]);
      chk(cp_d[i] == ecp_d[i], "R2 payload", cp_d[i], ecp_d[i]);
    end
    chk(rl_n == erl_n, gaps ? "R8 run count with gaps" : "R6 run count", rl_n, erl_n);
    for (int i = 0; i < erl_n && i < rl_n; i++) begin
      chk(rl_r[i] == erl_r[i], (erl_d[i] == 0) ? "R4 saturated run" : "R3 run", rl_r[i], erl_r[i]);
      chk(rl_d[i] == erl_d[i], "R3 run payload", rl_d[i], erl_d[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_data = '0;
    cp_n = 0; rl_n = 0; done_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(done == 1'b0, "R9 done after reset", int'(done), 0);
    chk(cp_valid == 1'b0, "R9 cp_valid after reset", int'(cp_valid), 0);
    chk(rl_valid == 1'b0, "R9 rl_valid after reset", int'(rl_valid), 0);
    chk(in_ready == 1'b1, "R8 ready high", int'(in_ready), 1);
    // pattern 0b101100: positions 2,3,5 nonzero (worked example, R1 R5)
    run_fiber(6'b101100, 1'b0);
    chk(int'(got_bm) == 6'b001101, "R1 example mask", int'(got_bm), 6'b001101);
    for (int pat = 0; pat < 64; pat++) run_fiber(pat, 1'b0);
    for (int pat = 0; pat < 64; pat++) run_fiber(pat, 1'b1);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule